// File: doc/BRIEF.md
# Atomic reservation monitor for load-locked / store-conditional

This block arbitrates the reservations behind load-locked / store-conditional pairs for a set of hardware contexts that share one memory. Each context owns one reservation slot holding a flag and the physical address of its last locked load. The block sees at most one memory request per cycle, tagged with the issuing context, the physical address, the direction (read or write), a locked qualifier and an uncacheable qualifier. From these it decides whether a store-conditional may proceed, reports a two-bit outcome code, drives the memory write enable, and removes reservations that a committed store has overtaken.

Reservations cover an aligned 16-byte block: the four least significant address bits never take part in a comparison. Each context also has a saturating count of consecutive failed store-conditionals. Whenever that count lands on a multiple of a fixed interval (100000 by default), a one-cycle warning naming the context is raised, so software livelock can be spotted.

All outputs are registered: a request presented before a rising edge shows its result, write enable, warning and updated slot and counter state during the following cycle. Each reservation slot is a two-state machine: `SLOT_FREE` and `SLOT_HELD`, with transitions *arm* (FREE to HELD, or HELD re-armed at a new address on a locked load), *kill* (HELD to FREE, on the owner's failed store-conditional or on a committed store to the same block) and reset (to FREE). Each failure tracker is a three-state machine: `TRK_CLEAN` (count zero), `TRK_COUNTING` and `TRK_PINNED` (count at its ceiling), with transitions *fail* (CLEAN to COUNTING, COUNTING to PINNED when the count reaches its maximum), *clear* (any state to CLEAN on a successful or uncacheable store-conditional) and reset (to CLEAN).

Top module: `resv_monitor`

## Requirements
- R1: A valid locked read from context c moves slot c to held and records the request's physical address as that slot's lock address; `resv_held_o[c]` is 1 in the following cycle.
- R2: All reservation comparisons use only address bits above bit 3, so any two addresses inside the same aligned 16-byte block match.
- R3: A locked, cacheable write from context c whose slot is held with a lock address in the store's block returns code 1 (binary 01) with `res_valid_o`, asserts `mem_wr_en_o`, and sets context c's failure count to 0.
- R4: A locked, cacheable write from context c that does not meet the R3 condition returns code 0 (binary 00), leaves `mem_wr_en_o` low, clears slot c, and adds one to context c's failure count.
- R5: A locked, uncacheable write returns code 2 (binary 10), asserts `mem_wr_en_o`, and sets the requester's failure count to 0.
- R6: Every write that reaches memory (ordinary store, successful store-conditional, uncacheable store-conditional) clears every held slot, including the requester's, whose lock address is in the store's block; slots in other blocks are untouched.
- R7: Ordinary reads, and cycles with `req_valid_i` low, change no slot and no counter and produce no result and no write.
- R8: `res_valid_o` is high for exactly the one cycle after each store-conditional request and never otherwise; the code is never 3.
- R9: When a failure increments context c's count to a nonzero multiple of `WARN_EVERY`, `warn_valid_o` pulses for one cycle with `warn_ctx_o` equal to c.
- R10: A failure count at its all-ones maximum stays there on further failures, and raises no further warning.
- R11: After reset every slot is free, every failure count is 0, and `res_valid_o`, `mem_wr_en_o` and `warn_valid_o` are low.
- R12: An ordinary (non-locked) write asserts `mem_wr_en_o` for one cycle without raising `res_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A request is present this cycle |
| req_ctx_i | input | CTX_W | Issuing context index |
| req_addr_i | input | ADDR_W | Physical address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_locked_i | input | 1 | Locked read or store-conditional qualifier |
| req_uncached_i | input | 1 | Address is uncacheable |
| res_valid_o | output | 1 | Store-conditional outcome strobe |
| res_code_o | output | 2 | Outcome: 0 fail, 1 success, 2 uncacheable |
| mem_wr_en_o | output | 1 | Write to memory proceeds |
| warn_valid_o | output | 1 | Consecutive-failure warning pulse |
| warn_ctx_o | output | CTX_W | Context named by the warning |
| resv_held_o | output | N_CTX | Per-context reservation flag |
| fail_cnt_o | output | N_CTX*CNT_W | Per-context failure counts, context 0 in the low bits |

## Verification
The embedded assertions watch, on every cycle, that a failure outcome never comes with a write while success and uncacheable outcomes always do, that the outcome code stays legal, that a failed store-conditional leaves its slot free, that plain reads leave every slot unchanged, that at most one warning source fires, and that a pinned counter sits at its ceiling. What only the bench's scenarios can show is the cross-context effect of a store on other contexts' reservations, block-granular matching with differing low address bits, the exact warning cadence up to saturation, and the reset of counts by success and by uncacheable store-conditionals, all compared against a reference model of the slots and counters driven by mixed directed and seeded random traffic.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [1:0] {
        SC_FAIL    = 2'd0,
        SC_PASS    = 2'd1,
        SC_NOCACHE = 2'd2
    } sc_code_e;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_LL    = 3'd2,
        OP_STORE = 3'd3,
        OP_SC    = 3'd4,
        OP_SC_UC = 3'd5
    } op_kind_e;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    typedef enum logic [1:0] {
        TRK_CLEAN    = 2'd0,
        TRK_COUNTING = 2'd1,
        TRK_PINNED   = 2'd2
    } trk_state_e;

    function automatic op_kind_e classify(input logic v, input logic wr,
                                          input logic lk, input logic uc);
        op_kind_e k;
        if (!v)             k = OP_IDLE;
        else if (!wr && lk) k = OP_LL;
        else if (!wr)       k = OP_LOAD;
        else if (!lk)       k = OP_STORE;
        else if (uc)        k = OP_SC_UC;
        else                k = OP_SC;
        return k;
    endfunction

endpackage

// File: rtl/resv_slot.sv
module resv_slot
    import resv_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int BLK_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [ADDR_W-1:0] arm_addr_i,
    input  logic              snoop_i,
    input  logic              drop_i,
    input  logic [ADDR_W-1:0] cmp_addr_i,
    output logic              held_o,
    output logic              hit_o
);
    localparam int TAG_LO = BLK_BITS;

    slot_state_e       st_q, st_d;
    logic [ADDR_W-1:0] lock_addr_q;
    logic              blk_eq;
    logic              kill;

    assign blk_eq = (lock_addr_q[ADDR_W-1:TAG_LO] == cmp_addr_i[ADDR_W-1:TAG_LO]);
    assign kill   = (snoop_i && blk_eq) || drop_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_FREE: if (arm_i) st_d = SLOT_HELD;
            SLOT_HELD: begin
                if (arm_i)      st_d = SLOT_HELD;
                else if (kill)  st_d = SLOT_FREE;
            end
            default: st_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SLOT_FREE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lock_addr_q <= '0;
        else if (arm_i) lock_addr_q <= arm_addr_i;
    end

    assign held_o = (st_q == SLOT_HELD);
    assign hit_o  = held_o && blk_eq;

    assert_arm_records_R1: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (held_o && lock_addr_q == $past(arm_addr_i)));

    assert_kill_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && snoop_i && blk_eq) |=> !held_o);

endmodule

// File: rtl/fail_tracker.sv
module fail_tracker
    import resv_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int WARN_EVERY = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fail_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             warn_o
);
    localparam int               PH_W    = (WARN_EVERY > 1) ? $clog2(WARN_EVERY) : 1;
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(WARN_EVERY - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - 1'b1;

    trk_state_e      st_q, st_d;
    logic [PH_W-1:0] phase_q;
    logic            bump;

    assign bump = fail_i && !clear_i && (st_q != TRK_PINNED);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TRK_CLEAN: begin
                if (bump) st_d = (cnt_o == CNT_PRE) ? TRK_PINNED : TRK_COUNTING;
            end
            TRK_COUNTING: begin
                if (clear_i)                    st_d = TRK_CLEAN;
                else if (bump && cnt_o == CNT_PRE) st_d = TRK_PINNED;
            end
            TRK_PINNED: if (clear_i) st_d = TRK_CLEAN;
            default: st_d = TRK_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TRK_CLEAN;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o   <= '0;
            phase_q <= '0;
            warn_o  <= 1'b0;
        end else begin
            warn_o <= 1'b0;
            if (clear_i) begin
                cnt_o   <= '0;
                phase_q <= '0;
            end else if (bump) begin
                cnt_o <= cnt_o + 1'b1;
                if (phase_q == PH_LAST) begin
                    phase_q <= '0;
                    warn_o  <= 1'b1;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end
        end
    end

    assert_pinned_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TRK_PINNED) |-> (cnt_o == CNT_MAX));

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && !clear_i) |=> (cnt_o == CNT_MAX));

    assert_warn_multiple_R9: assert property (@(posedge clk) disable iff (!rst_n)
        warn_o |-> (cnt_o != '0 && (int'(cnt_o) % WARN_EVERY) == 0));

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int N_CTX      = 4,
    parameter int ADDR_W     = 40,
    parameter int CNT_W      = 20,
    parameter int WARN_EVERY = 100000,
    parameter int BLK_BITS   = 4,
    localparam int CTX_W     = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid_i,
    input  logic [CTX_W-1:0]        req_ctx_i,
    input  logic [ADDR_W-1:0]       req_addr_i,
    input  logic                    req_write_i,
    input  logic                    req_locked_i,
    input  logic                    req_uncached_i,
    output logic                    res_valid_o,
    output logic [1:0]              res_code_o,
    output logic                    mem_wr_en_o,
    output logic                    warn_valid_o,
    output logic [CTX_W-1:0]        warn_ctx_o,
    output logic [N_CTX-1:0]        resv_held_o,
    output logic [N_CTX*CNT_W-1:0]  fail_cnt_o
);
    op_kind_e         op;
    logic             ctx_ok;
    logic [N_CTX-1:0] hit_vec;
    logic [N_CTX-1:0] warn_vec;
    logic             own_hit;
    logic             sc_pass, sc_fail, commit, cnt_clear;

    assign ctx_ok = (int'(req_ctx_i) < N_CTX);
    assign op     = classify(req_valid_i && ctx_ok, req_write_i,
                             req_locked_i, req_uncached_i);

    always_comb begin
        own_hit = 1'b0;
        for (int i = 0; i < N_CTX; i++) begin
            if (req_ctx_i == CTX_W'(i)) own_hit = hit_vec[i];
        end
    end

    assign sc_pass   = (op == OP_SC) && own_hit;
    assign sc_fail   = (op == OP_SC) && !own_hit;
    assign commit    = (op == OP_STORE) || (op == OP_SC_UC) || sc_pass;
    assign cnt_clear = sc_pass || (op == OP_SC_UC);

    for (genvar g = 0; g < N_CTX; g++) begin : g_ctx
        logic mine;
        assign mine = (req_ctx_i == CTX_W'(g));

        resv_slot #(
            .ADDR_W  (ADDR_W),
            .BLK_BITS(BLK_BITS)
        ) slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .arm_i     ((op == OP_LL) && mine),
            .arm_addr_i(req_addr_i),
            .snoop_i   (commit),
            .drop_i    (sc_fail && mine),
            .cmp_addr_i(req_addr_i),
            .held_o    (resv_held_o[g]),
            .hit_o     (hit_vec[g])
        );

        fail_tracker #(
            .CNT_W     (CNT_W),
            .WARN_EVERY(WARN_EVERY)
        ) trk_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .fail_i (sc_fail && mine),
            .clear_i(cnt_clear && mine),
            .cnt_o  (fail_cnt_o[g*CNT_W +: CNT_W]),
            .warn_o (warn_vec[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            res_code_o  <= SC_FAIL;
            mem_wr_en_o <= 1'b0;
        end else begin
            res_valid_o <= (op == OP_SC) || (op == OP_SC_UC);
            mem_wr_en_o <= commit;
            unique case (op)
                OP_SC:    res_code_o <= sc_pass ? SC_PASS : SC_FAIL;
                OP_SC_UC: res_code_o <= SC_NOCACHE;
                default:  res_code_o <= SC_FAIL;
            endcase
        end
    end

    always_comb begin
        warn_ctx_o = '0;
        for (int i = 0; i < N_CTX; i++) begin
            if (warn_vec[i]) warn_ctx_o = CTX_W'(i);
        end
    end
    assign warn_valid_o = |warn_vec;

    assert_fail_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_code_o == SC_FAIL) |-> !mem_wr_en_o);

    assert_fail_drops_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_code_o == SC_FAIL) |-> !resv_held_o[$past(req_ctx_i)]);

    assert_pass_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_code_o != SC_FAIL) |-> mem_wr_en_o);

    assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_code_o != 2'd3));

    assert_load_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD || op == OP_IDLE) |=> (resv_held_o == $past(resv_held_o)));

    assert_single_warn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(warn_vec));

endmodule

// File: tb/resv_monitor_tb_top.sv
module resv_monitor_tb_top;
    localparam int N   = 4;
    localparam int AW  = 16;
    localparam int CW  = 4;
    localparam int WE  = 5;
    localparam int XW  = 2;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [XW-1:0] req_ctx = '0;
    logic [AW-1:0] req_addr = '0;
    logic req_write = 1'b0, req_locked = 1'b0, req_uncached = 1'b0;
    logic res_valid, mem_wr_en, warn_valid;
    logic [1:0] res_code;
    logic [XW-1:0] warn_ctx;
    logic [N-1:0] resv_held;
    logic [N*CW-1:0] fail_cnt;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit            m_held [N];
    logic [AW-1:0] m_addr [N];
    int            m_cnt  [N];

    always #4 clk = ~clk;

    resv_monitor #(.N_CTX(N), .ADDR_W(AW), .CNT_W(CW), .WARN_EVERY(WE), .BLK_BITS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ctx_i(req_ctx),
        .req_addr_i(req_addr), .req_write_i(req_write), .req_locked_i(req_locked),
        .req_uncached_i(req_uncached), .res_valid_o(res_valid), .res_code_o(res_code),
        .mem_wr_en_o(mem_wr_en), .warn_valid_o(warn_valid), .warn_ctx_o(warn_ctx),
        .resv_held_o(resv_held), .fail_cnt_o(fail_cnt));

    function automatic bit same_blk(input logic [AW-1:0] a, input logic [AW-1:0] b);
        return a[AW-1:4] == b[AW-1:4];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        for (int c = 0; c < N; c++) begin
            chk(resv_held[c] == m_held[c], tag, int'(resv_held[c]), int'(m_held[c]));
            chk(int'(fail_cnt[c*CW +: CW]) == m_cnt[c], "R10 count", int'(fail_cnt[c*CW +: CW]), m_cnt[c]);
        end
    endtask

    // one request: drive at negedge, compute expectations, sample 2 ns after the edge
    task automatic step(input bit v, input int ctx, input logic [AW-1:0] a,
                        input bit wr, input bit lk, input bit uc);
        bit e_rv = 0, e_wr = 0, e_warn = 0, commit = 0;
        int e_code = 0;
        string tag = "R7";
        req_valid = v; req_ctx = XW'(ctx); req_addr = a;
        req_write = wr; req_locked = lk; req_uncached = uc;
        if (v && !wr && lk) begin
            tag = "R1"; m_held[ctx] = 1; m_addr[ctx] = a;
        end else if (v && wr && !lk) begin
            tag = "R12"; e_wr = 1; commit = 1;
        end else if (v && wr && uc) begin
            tag = "R5"; e_rv = 1; e_code = 2; e_wr = 1; commit = 1; m_cnt[ctx] = 0;
        end else if (v && wr) begin
            e_rv = 1;
            if (m_held[ctx] && same_blk(m_addr[ctx], a)) begin
                tag = "R3"; e_code = 1; e_wr = 1; commit = 1; m_cnt[ctx] = 0;
            end else begin
                tag = "R4"; e_code = 0; m_held[ctx] = 0;
                if (m_cnt[ctx] < CMAX) begin
                    m_cnt[ctx]++;
                    e_warn = (m_cnt[ctx] % WE) == 0;
                end
            end
        end
        if (commit)
            for (int c = 0; c < N; c++)
                if (same_blk(m_addr[c], a)) m_held[c] = 0;
        @(posedge clk);
        #2;
        chk(res_valid == e_rv, "R8 res_valid", int'(res_valid), int'(e_rv));
        if (e_rv) chk(int'(res_code) == e_code, tag, int'(res_code), e_code);
        chk(mem_wr_en == e_wr, tag, int'(mem_wr_en), int'(e_wr));
        chk(warn_valid == e_warn, "R9 warn", int'(warn_valid), int'(e_warn));
        if (e_warn) chk(int'(warn_ctx) == ctx, "R9 warn ctx", int'(warn_ctx), ctx);
        check_state(commit ? "R6 held" : tag);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < N; c++) begin m_held[c] = 0; m_addr[c] = '0; m_cnt[c] = 0; end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(!res_valid && !mem_wr_en && !warn_valid, "R11 outputs", int'({res_valid, mem_wr_en, warn_valid}), 0);
        check_state("R11 held");

        step(1, 0, 16'h1234, 0, 1, 0);          // R1 arm context 0
        step(1, 0, 16'h123C, 1, 1, 0);          // R2 R3 other low bits, same block: pass
        step(1, 0, 16'h1230, 1, 1, 0);          // R4 no reservation: fail
        step(1, 1, 16'h2000, 0, 1, 0);
        step(1, 2, 16'h2008, 0, 1, 0);
        step(1, 3, 16'h3000, 0, 1, 0);
        step(1, 3, 16'h200F, 1, 0, 0);          // R6 R12 store clears ctx1 and ctx2, ctx3 kept
        step(1, 1, 16'h3000, 0, 1, 0);
        step(1, 0, 16'h3004, 0, 1, 0);
        step(1, 0, 16'h3000, 1, 1, 0);          // R6 pass by ctx0 clears ctx1, ctx3 too
        step(1, 2, 16'h4000, 0, 1, 0);
        step(1, 1, 16'h4000, 0, 0, 0);          // R7 ordinary load, no effect
        step(1, 2, 16'h5000, 0, 0, 0);          // R7
        step(0, 2, 16'h4000, 1, 0, 0);          // R7 idle cycle carrying a store
        step(1, 2, 16'h4010, 1, 1, 0);          // R2 R4 next block: fail
        step(1, 3, 16'h6000, 1, 1, 1);          // R5 uncached SC
        for (int k = 0; k < 18; k++) step(1, 1, 16'h7000, 1, 1, 0); // R9 R10 warnings then pin
        step(1, 1, 16'h7000, 1, 1, 1);          // R5 uncached clears count

        for (int k = 0; k < 4000; k++) begin
            int op = $urandom_range(0, 9);
            logic [AW-1:0] a = {10'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
            int c = $urandom_range(0, N - 1);
            case (op)
                0, 1, 2: step(1, c, a, 0, 1, 0);
                3:       step(1, c, a, 0, 0, $urandom_range(0, 1) == 1);
                4:       step(1, c, a, 1, 0, 0);
                5:       step(1, c, a, 1, 1, 1);
                6:       step(0, c, a, 1, 1, 0);
                default: step(1, c, a, 1, 1, 0);
            endcase
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule